// File: doc/BRIEF.md
# Stacked Asynchronous SRAM Controller

This block connects a synchronous request port to a stacked asynchronous static RAM of 2M x 16 words. The stack has four banks of 512K words each, and every bank is two bytes wide. A requester presents one word at a time: a read or write flag, a 21-bit word address, write data and a byte-enable pair. It uses a valid/ready handshake. The controller holds ready low for the whole of each access.

The two upper address bits pick one of four active-low bank selects. The lower 19 bits go out unchanged as the device address. The per-byte write and output strobes follow the byte enables. Every strobe width is a whole number of clock cycles, and each count is rounded up from a nanosecond parameter using the clock period.

Read data is sampled on the last access cycle and returned with a one-cycle valid pulse. Lanes that were not enabled read back as zero. When a write follows a read, idle turnaround cycles come before the controller drives the bus. This gives the memory time to release the bus.

Top module: `sram_stack_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, every bank select, write strobe and output strobe is high (inactive), and `mem_dq_drive` is 0.
- R2: During an access exactly one bank select is low: bit `req_addr[20:19]` of `mem_ce_n`. `mem_addr` equals `req_addr[18:0]` for the whole access. At most one bank select is ever low.
- R3: A write holds write strobe bit `k` (`k`=0 for bits 7:0, `k`=1 for bits 15:8) low exactly when `req_be[k]` is 1. The strobe stays low for ceil(T_WP_NS / period) cycles, which is 3 at the defaults and a 200 MHz clock. `mem_dq_drive` is 1 and `mem_dq_out` carries the write data in every one of those cycles. With both byte enables 0, no write strobe falls and the memory keeps its contents.
- R4: `mem_dq_drive` stays 1 for one cycle after the write strobes rise, and it is 1 whenever any write strobe is low.
- R5: A read holds the bank select low and output strobe bit `k` low exactly when `req_be[k]` is 1. This lasts ceil(max(T_AA_NS, T_OE_NS) / period) cycles, which is 5 at the defaults. All write strobes stay high, and no output strobe is ever low at the same time as a write strobe.
- R6: A read returns `rsp_valid` high for exactly one cycle, in the cycle after the last access cycle. `rsp_rdata` then holds the memory word, with the bytes of disabled lanes forced to zero.
- R7: `req_ready` is low from the cycle after a request is accepted until the access ends. A write lasts 4 cycles, a write after a read lasts 6 cycles, and a read lasts 5 cycles. Requests presented while ready is low are ignored, and the memory is left unchanged.
- R8: A write whose previous access was a read is preceded by ceil(T_TURN_NS / period) cycles (2 at the defaults). In those cycles all bank selects are high and `mem_dq_drive` is 0. A write after a write has no such gap.
- R9: `mem_dq_drive` is never 1 while any output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address; bits 20:19 pick the bank |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for the low byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Device address |
| mem_ce_n | output | 4 | Active-low bank selects |
| mem_we_n | output | 2 | Active-low write strobes per byte |
| mem_oe_n | output | 2 | Active-low output strobes per byte |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_drive | output | 1 | Enable for the data-bus output buffer |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
On every cycle the assertions check the electrical safety rules:
- at most one bank is selected;
- write and output strobes are never low together;
- the controller never drives the bus while an output strobe is low;
- each write pulse lasts exactly the derived cycle count, and the data is held one cycle after the pulse;
- ready stays low while a bank is selected;
- the response pulse lasts one cycle.

Only the bench's scenarios, run against a behavioural memory, can show the rest:
- data integrity across banks;
- byte-lane merging and read masking;
- the read-to-write turnaround gap, as opposed to no gap between writes;
- that requests made while busy are dropped.

// File: rtl/sram_stack_pkg.sv
package sram_stack_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_TURN  = 3'd1,
      ST_WRITE = 3'd2,
      ST_WHOLD = 3'd3,
      ST_READ  = 3'd4
   } seq_state_e;

   // Whole cycles covering a nanosecond figure, never fewer than one.
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      int c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
   parameter int SEL_W = 2,
   localparam int BANKS = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [BANKS-1:0] ce_n
);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign ce_n[b] = ~(en && (sel == SEL_W'(b)));
   end

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe #(
   parameter int LANES = 2
) (
   input  logic             wr_act,
   input  logic             rd_act,
   input  logic [LANES-1:0] be,
   output logic [LANES-1:0] we_n,
   output logic [LANES-1:0] oe_n
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign we_n[l] = ~(wr_act && be[l]);
      assign oe_n[l] = ~(rd_act && be[l]);
   end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_stack_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter int WP_CYC   = 3,
   parameter int AA_CYC   = 5,
   parameter int TURN_CYC = 2,
   localparam int MAXC    = max2(max2(WP_CYC, AA_CYC), TURN_CYC),
   localparam int CNT_W   = $clog2(MAXC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              req_ready,
   output seq_state_e        state,
   output logic              rd_last,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  be_q
);

   seq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             after_rd;

   localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] AA_LAST   = CNT_W'(AA_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         after_rd <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (req_valid) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  if (req_write) st <= after_rd ? ST_TURN : ST_WRITE;
                  else           st <= ST_READ;
               end
            end
            ST_TURN: begin
               if (cnt == TURN_LAST) begin
                  cnt <= '0;
                  st  <= ST_WRITE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WRITE: begin
               if (cnt == WP_LAST) begin
                  cnt <= '0;
                  st  <= ST_WHOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WHOLD: begin
               after_rd <= 1'b0;
               st       <= ST_IDLE;
            end
            ST_READ: begin
               if (cnt == AA_LAST) begin
                  cnt      <= '0;
                  after_rd <= 1'b1;
                  st       <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign state     = st;
   assign req_ready = (st == ST_IDLE);
   assign rd_last   = (st == ST_READ) && (cnt == AA_LAST);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   localparam int LANE_W = DATA_W / LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata,
   output logic              valid
);

   logic [DATA_W-1:0] masked;

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign masked[l*LANE_W +: LANE_W] = be[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cap;
         if (cap) rdata <= masked;
      end
   end

endmodule

// File: rtl/sram_stack_ctrl.sv
module sram_stack_ctrl
   import sram_stack_pkg::*;
#(
   parameter int ADDR_W        = 21,
   parameter int DEV_ADDR_W    = 19,
   parameter int DATA_W        = 16,
   parameter int LANES         = 2,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int T_WP_NS       = 15,
   parameter int T_DW_NS       = 10,
   parameter int T_AA_NS       = 25,
   parameter int T_OE_NS       = 12,
   parameter int T_TURN_NS     = 10,
   localparam int SEL_W    = ADDR_W - DEV_ADDR_W,
   localparam int BANKS    = 1 << SEL_W,
   localparam int WP_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_PS), ns_to_cyc(T_DW_NS, CLK_PERIOD_PS)),
   localparam int AA_CYC   = max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_PS), ns_to_cyc(T_OE_NS, CLK_PERIOD_PS)),
   localparam int TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_PERIOD_PS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [LANES-1:0]      req_be,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [DEV_ADDR_W-1:0] mem_addr,
   output logic [BANKS-1:0]      mem_ce_n,
   output logic [LANES-1:0]      mem_we_n,
   output logic [LANES-1:0]      mem_oe_n,
   output logic [DATA_W-1:0]     mem_dq_out,
   output logic                  mem_dq_drive,
   input  logic [DATA_W-1:0]     mem_dq_in
);

   // Elaboration-time parameter checks
   if (ADDR_W <= DEV_ADDR_W) begin : g_bad_addr
      $error("ADDR_W must exceed DEV_ADDR_W");
   end
   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES");
   end
   if (CLK_PERIOD_PS <= 0) begin : g_bad_clk
      $error("CLK_PERIOD_PS must be positive");
   end

   seq_state_e        state;
   logic              rd_last;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic              wr_act;
   logic              rd_act;

   sram_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .LANES    (LANES),
      .WP_CYC   (WP_CYC),
      .AA_CYC   (AA_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .req_ready (req_ready),
      .state     (state),
      .rd_last   (rd_last),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .be_q      (be_q)
   );

   assign wr_act = (state == ST_WRITE);
   assign rd_act = (state == ST_READ);

   sram_bank_decode #(.SEL_W(SEL_W)) u_dec (
      .en   (wr_act || rd_act),
      .sel  (addr_q[ADDR_W-1:DEV_ADDR_W]),
      .ce_n (mem_ce_n)
   );

   sram_lane_strobe #(.LANES(LANES)) u_strb (
      .wr_act (wr_act),
      .rd_act (rd_act),
      .be     (be_q),
      .we_n   (mem_we_n),
      .oe_n   (mem_oe_n)
   );

   sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (rd_last),
      .be    (be_q),
      .dq_in (mem_dq_in),
      .rdata (rsp_rdata),
      .valid (rsp_valid)
   );

   assign mem_addr     = addr_q[DEV_ADDR_W-1:0];
   assign mem_dq_out   = wdata_q;
   assign mem_dq_drive = wr_act || (state == ST_WHOLD);

endmodule

// File: rtl/sram_stack_ctrl_chk.sv
module sram_stack_ctrl_chk #(
   parameter int BANKS  = 4,
   parameter int LANES  = 2,
   parameter int WP_CYC = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [BANKS-1:0] mem_ce_n,
   input logic [LANES-1:0] mem_we_n,
   input logic [LANES-1:0] mem_oe_n,
   input logic             mem_dq_drive
);

   logic [7:0] wlow_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wlow_cnt <= '0;
      else if (!(&mem_we_n))     wlow_cnt <= (wlow_cnt == 8'hFF) ? wlow_cnt : wlow_cnt + 1'b1;
      else                       wlow_cnt <= '0;
   end

   // R2
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_ce_n) <= 1);

   // R9
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drive |-> (&mem_oe_n));

   // R5
   rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_oe_n) |-> (&mem_we_n));

   // R3
   write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&mem_we_n) |-> (wlow_cnt == 8'(WP_CYC)));

   // R4
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&mem_we_n) |-> mem_dq_drive);

   // R4
   we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_we_n) |-> (mem_dq_drive && !(&mem_ce_n)));

   // R7
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_ce_n) |-> !req_ready);

   // R6
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind sram_stack_ctrl sram_stack_ctrl_chk #(
   .BANKS  (BANKS),
   .LANES  (LANES),
   .WP_CYC (WP_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .mem_ce_n     (mem_ce_n),
   .mem_we_n     (mem_we_n),
   .mem_oe_n     (mem_oe_n),
   .mem_dq_drive (mem_dq_drive)
);

// File: tb/sram_stack_ctrl_tb.sv
`timescale 1ns/1ps
module sram_stack_ctrl_tb;

   localparam int WP = 3;
   localparam int AA = 5;
   localparam int TURN = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [18:0] mem_addr;
   logic [3:0]  mem_ce_n;
   logic [1:0]  mem_we_n;
   logic [1:0]  mem_oe_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_drive;
   logic [15:0] mem_dq_in;

   int checks = 0;
   int fails = 0;
   int contention = 0;
   bit prev_rd = 1'b0;

   always #2.5 clk = ~clk;

   sram_stack_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
      .mem_dq_in(mem_dq_in)
   );

   // Behavioural memory: 4 banks of 512K x 16
   logic [15:0] mem [int];

   always @(posedge clk) begin
      for (int b = 0; b < 4; b++) begin
         if (!mem_ce_n[b] && !(&mem_we_n)) begin
            int k;
            logic [15:0] w;
            k = b * (1 << 19) + int'(mem_addr);
            w = mem.exists(k) ? mem[k] : 16'h0000;
            for (int l = 0; l < 2; l++)
               if (!mem_we_n[l]) w[l*8 +: 8] = mem_dq_drive ? mem_dq_out[l*8 +: 8] : 8'hXX;
            mem[k] = w;
         end
      end
   end

   always @* begin
      mem_dq_in = 16'hA5A5;
      for (int b = 0; b < 4; b++) begin
         if (!mem_ce_n[b] && (&mem_we_n)) begin
            int k;
            logic [15:0] w;
            k = b * (1 << 19) + int'(mem_addr);
            w = mem.exists(k) ? mem[k] : 16'h0000;
            for (int l = 0; l < 2; l++)
               if (!mem_oe_n[l]) mem_dq_in[l*8 +: 8] = w[l*8 +: 8];
         end
      end
   end

   // R9 bus contention monitor
   always @(negedge clk)
      if (rst_n && mem_dq_drive && !(&mem_ce_n) && !(&mem_oe_n) && (&mem_we_n))
         contention++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input logic [20:0] a, input logic [15:0] d,
                        input logic [1:0] be, input logic [15:0] exp, input bit poke);
      int n = 0, we_cnt = 0, oe_cnt = 0, turn = 0;
      int bad_ce = 0, bad_pat = 0, bad_drv = 0;
      int exp_turn, exp_busy;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready && n < 100) begin
         n++;
         if (!(&mem_we_n)) begin
            we_cnt++;
            if (mem_we_n != ~be) bad_pat++;
            if (!mem_dq_drive || mem_dq_out != d) bad_drv++;
         end
         if (!(&mem_oe_n)) begin
            oe_cnt++;
            if (mem_oe_n != ~be) bad_pat++;
         end
         if (!(&mem_ce_n)) begin
            if (mem_ce_n != ~(4'b0001 << a[20:19]) || mem_addr != a[18:0]) bad_ce++;
         end else if (!mem_dq_drive) begin
            turn++;
         end
         if (poke && n == 2) begin
            req_valid = 1'b1; req_write = 1'b1; req_wdata = 16'hDEAD; req_be = 2'b11;
         end else if (poke && n == 3) begin
            chk(!req_ready, "R7", "ready while busy", req_ready, 0);
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      exp_turn = (wr && prev_rd) ? TURN : 0;
      exp_busy = wr ? exp_turn + WP + 1 : AA;
      chk(bad_ce == 0, "R2", "bank select/address mismatches", bad_ce, 0);
      chk(n == exp_busy, "R7", "busy cycles", n, exp_busy);
      if (wr) begin
         chk(we_cnt == ((be != 0) ? WP : 0), "R3", "write strobe cycles", we_cnt, (be != 0) ? WP : 0);
         chk(bad_pat == 0 && bad_drv == 0, "R3", "strobe lanes/data errors", bad_pat + bad_drv, 0);
         chk(turn == exp_turn, "R8", "turnaround cycles", turn, exp_turn);
      end else begin
         chk(oe_cnt == ((be != 0) ? AA : 0) && we_cnt == 0, "R5", "output strobe cycles", oe_cnt, (be != 0) ? AA : 0);
         chk(bad_pat == 0, "R5", "output strobe lanes", bad_pat, 0);
         chk(rsp_valid == 1'b1, "R6", "rsp_valid at end", rsp_valid, 1);
         chk(rsp_rdata == exp, "R6", "read data", rsp_rdata, exp);
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R6", "rsp_valid pulse width", rsp_valid, 0);
      end
      prev_rd = !wr;
   endtask

   // {write, addr[20:0], wdata, be, expected read}
   localparam logic [55:0] VEC [0:10] = '{
      {1'b1, 21'h000005, 16'h1234, 2'b11, 16'h0000},
      {1'b0, 21'h000005, 16'h0000, 2'b11, 16'h1234},
      {1'b1, 21'h080010, 16'hABCD, 2'b11, 16'h0000},
      {1'b1, 21'h080010, 16'h5566, 2'b01, 16'h0000},
      {1'b0, 21'h080010, 16'h0000, 2'b11, 16'hAB66},
      {1'b0, 21'h080010, 16'h0000, 2'b10, 16'hAB00},
      {1'b1, 21'h1FFFFF, 16'hFFEE, 2'b10, 16'h0000},
      {1'b0, 21'h1FFFFF, 16'h0000, 2'b11, 16'hFF00},
      {1'b1, 21'h100000, 16'h0F0F, 2'b11, 16'h0000},
      {1'b0, 21'h100000, 16'h0000, 2'b01, 16'h000F},
      {1'b0, 21'h000005, 16'h0000, 2'b11, 16'h1234}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state while held
      chk(req_ready && !rsp_valid && (&mem_ce_n) && (&mem_we_n) && (&mem_oe_n) && !mem_dq_drive,
          "R1", "outputs in reset", {req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 12'hBFE);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && (&mem_ce_n) && (&mem_we_n) && (&mem_oe_n) && !mem_dq_drive,
          "R1", "outputs after reset", {req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}, 12'hBFE);

      for (int i = 0; i < 11; i++)
         do_op(VEC[i][55], VEC[i][54:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0], 1'b0);

      // R7: write presented while a read is busy is ignored
      do_op(1'b0, 21'h000005, 16'h0000, 2'b11, 16'h1234, 1'b1);
      do_op(1'b0, 21'h000005, 16'h0000, 2'b11, 16'h1234, 1'b0);

      // R3: write with no byte enabled leaves memory unchanged
      do_op(1'b1, 21'h000005, 16'hFFFF, 2'b00, 16'h0000, 1'b0);
      do_op(1'b0, 21'h000005, 16'h0000, 2'b11, 16'h1234, 1'b0);

      // R8: back-to-back writes have no turnaround
      do_op(1'b1, 21'h080020, 16'h7788, 2'b11, 16'h0000, 1'b0);
      do_op(1'b1, 21'h080021, 16'h99AA, 2'b11, 16'h0000, 1'b0);
      do_op(1'b0, 21'h080020, 16'h0000, 2'b11, 16'h7788, 1'b0);

      chk(contention == 0, "R9", "cycles driving while memory outputs on", contention, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule